// File: doc/BRIEF.md
# Cycle-Countdown Interrupt Timer with Selectable Watch Width

This block is a CPU-cycle interrupt timer that sits on a memory-mapped write bus. Software builds a 16-bit reload value four bits at a time, copies it into a down counter with a separate command, and then arms the timer through a control write. The control write sets an enable bit and a 3-bit mode. While the timer is armed and the counter is nonzero, it counts down once for each cycle-enable pulse.

The mode selects which part of the counter is watched. Mode 0 fires when the whole counter reaches zero. The other modes fire when the decrement carries out of the low 12, 8 or 4 bits, which makes the timer behave like a 12-, 8- or 4-bit timer. A firing event does not reload the counter. It clears the counter and the enable bit, and it raises a level interrupt request that stays high until the next control write.

Reset is asynchronous and active low on the pin. Inside the block it is released through a two-stage synchronizer, so registers leave reset two clock edges after the pin rises.

Top module: `cyc_irq_timer`

## Requirements
- R1: A write to address 0xE000+n (n = 0..3) loads the 4-bit data into reload-value bits 4n+3:4n. The other bits are left unchanged.
- R2: A write to 0xF000 copies the full 16-bit reload value into the counter, whatever data is written. The copy is visible from the next clock edge.
- R3: A write to 0xF001 sets enable from data bit 0 and mode from data bits 3:1. From the following cycle the interrupt request is low.
- R4: The counter decreases by exactly one on each clock edge where all of the following hold: cyc_en is high, enable is set, the counter is nonzero, and no write to any of the six timer addresses takes place. On every other edge it holds its value, unless R2 or R9 applies.
- R5: In mode 0 the timer fires on the decrement that brings the counter to zero. A loaded value N therefore fires on the Nth counted pulse.
- R6: In mode 1 the timer fires on the decrement that changes counter bits 15:12. The firing pulse is number (N mod 4096)+1.
- R7: In modes 2 and 3 the timer fires on the decrement that changes bits 15:8. The firing pulse is number (N mod 256)+1.
- R8: In modes 4 to 7 the timer fires on the decrement that changes bits 15:4. The firing pulse is number (N mod 16)+1.
- R9: On firing, the counter becomes zero and enable is cleared, so no further counting takes place until a new reload and control write.
- R10: irq rises at the clock edge that samples the firing pulse. It stays high until a 0xF001 write or a reset.
- R11: After reset, the reload value and the counter are both 0xFFFF, enable and mode are 0, and irq is low.
- R12: In modes 1 to 7, a counter that reaches zero without the watched bits ever changing stops there and does not fire.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cpu_addr | input | 16 | CPU write address |
| cpu_data | input | 4 | Low nibble of the CPU write data |
| cpu_we | input | 1 | CPU write strobe, one cycle per write |
| cyc_en | input | 1 | One-cycle pulse for each CPU cycle to be counted |
| irq | output | 1 | Active-high interrupt request, held high until cleared |

## Verification
A register write takes effect at the clock edge that samples the strobe. irq rises at the same edge that samples the firing pulse, so it is high one cycle after the bench drives that pulse. The bench drives inputs on falling edges and keeps a running count of the qualifying pulses it has driven. The scoreboard entry for each armed case holds the pulse number that should cause the firing. A monitor wakes on the rising edge of irq and compares the running count at that instant with the entry. Cases that must stay silent check irq on a falling edge after their pulses end, and they treat any rise of irq as an unexpected event.

// File: rtl/cyc_irq_pkg.sv
package cyc_irq_pkg;
  localparam int unsigned CNT_W_DEF = 16;
  localparam int unsigned NIB_W     = 4;
  localparam int unsigned MODE_W    = 3;

  // which part of the counter is watched for a change on a decrement
  typedef enum logic [1:0] {
    WATCH_ALL   = 2'd0,
    WATCH_TOP4  = 2'd1,
    WATCH_TOP8  = 2'd2,
    WATCH_TOP12 = 2'd3
  } watch_e;

  function automatic watch_e decode_mode(input logic [MODE_W-1:0] m);
    watch_e w;
    if (m[2])      w = WATCH_TOP12;
    else if (m[1]) w = WATCH_TOP8;
    else if (m[0]) w = WATCH_TOP4;
    else           w = WATCH_ALL;
    return w;
  endfunction
endpackage

// File: rtl/cyc_irq_rst_sync.sv
module cyc_irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cyc_irq_regs.sv
module cyc_irq_regs
  import cyc_irq_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 16,
  parameter int unsigned       CNT_W       = CNT_W_DEF,
  parameter logic [ADDR_W-1:0] LATCH_BASE  = 16'hE000,
  parameter logic [ADDR_W-1:0] RELOAD_ADDR = 16'hF000,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 16'hF001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NIB_W-1:0]  bus_nib,
  input  logic              bus_we,
  input  logic              fire,
  output logic [CNT_W-1:0]  latch_o,
  output logic              reload_o,
  output logic              en_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              irq_o,
  output logic              wr_hit_o
);
  localparam int unsigned NIBBLES = CNT_W / NIB_W;

  logic [NIBBLES-1:0] nib_hit;
  logic               reload_hit;
  logic               ctrl_hit;

  logic [CNT_W-1:0]  latch_q, latch_d;
  logic              en_q, en_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              irq_q, irq_d;

  // one decoder per reload-value nibble
  for (genvar g = 0; g < NIBBLES; g++) begin : g_nib
    assign nib_hit[g] = bus_we && (bus_addr == ADDR_W'(LATCH_BASE + g));
  end

  assign reload_hit = bus_we && (bus_addr == RELOAD_ADDR);
  assign ctrl_hit   = bus_we && (bus_addr == CTRL_ADDR);

  always_comb begin
    latch_d = latch_q;
    for (int i = 0; i < int'(NIBBLES); i++) begin
      if (nib_hit[i]) latch_d[i*NIB_W +: NIB_W] = bus_nib;
    end
  end

  always_comb begin
    en_d   = en_q;
    mode_d = mode_q;
    irq_d  = irq_q;
    if (ctrl_hit) begin
      en_d   = bus_nib[0];
      mode_d = bus_nib[MODE_W:1];
      irq_d  = 1'b0;
    end else if (fire) begin
      en_d  = 1'b0;
      irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '1;
      en_q    <= 1'b0;
      mode_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      latch_q <= latch_d;
      en_q    <= en_d;
      mode_q  <= mode_d;
      irq_q   <= irq_d;
    end
  end

  assign latch_o  = latch_q;
  assign reload_o = reload_hit;
  assign en_o     = en_q;
  assign mode_o   = mode_q;
  assign irq_o    = irq_q;
  assign wr_hit_o = (|nib_hit) | reload_hit | ctrl_hit;
endmodule

// File: rtl/cyc_irq_count.sv
module cyc_irq_count
  import cyc_irq_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  watch_e           watch,
  input  logic             hold,
  input  logic             reload,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fire_o
);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
  localparam logic [CNT_W-1:0] MASK_T4  = ~({CNT_W{1'b1}} >> NIB_W);
  localparam logic [CNT_W-1:0] MASK_T8  = ~({CNT_W{1'b1}} >> (2*NIB_W));
  localparam logic [CNT_W-1:0] MASK_T12 = ~({CNT_W{1'b1}} >> (3*NIB_W));

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] dec;
  logic [CNT_W-1:0] flip;
  logic             step;
  logic             hit;
  logic             fire;

  always_comb begin
    step = tick && en && (cnt_q != '0) && !hold;
    dec  = cnt_q - ONE;
    flip = cnt_q ^ dec;
    unique case (watch)
      WATCH_ALL:   hit = (dec == '0);
      WATCH_TOP4:  hit = |(flip & MASK_T4);
      WATCH_TOP8:  hit = |(flip & MASK_T8);
      WATCH_TOP12: hit = |(flip & MASK_T12);
      default:     hit = 1'b0;
    endcase
    fire = step && hit;
  end

  always_comb begin
    if (reload)    cnt_d = load_val;
    else if (fire) cnt_d = '0;
    else if (step) cnt_d = dec;
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '1;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign fire_o = fire;
endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer
  import cyc_irq_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 16,
  parameter int unsigned       CNT_W       = CNT_W_DEF,
  parameter logic [ADDR_W-1:0] LATCH_BASE  = 16'hE000,
  parameter logic [ADDR_W-1:0] RELOAD_ADDR = 16'hF000,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 16'hF001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [NIB_W-1:0]  cpu_data,
  input  logic              cpu_we,
  input  logic              cyc_en,
  output logic              irq
);
  logic              rst_sync_n;
  logic [CNT_W-1:0]  latch_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              reload_stb;
  logic              en_q;
  logic [MODE_W-1:0] mode_q;
  logic              any_wr;
  logic              fire;
  watch_e            watch;

  cyc_irq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cyc_irq_regs #(
    .ADDR_W      (ADDR_W),
    .CNT_W       (CNT_W),
    .LATCH_BASE  (LATCH_BASE),
    .RELOAD_ADDR (RELOAD_ADDR),
    .CTRL_ADDR   (CTRL_ADDR)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .bus_addr (cpu_addr),
    .bus_nib  (cpu_data),
    .bus_we   (cpu_we),
    .fire     (fire),
    .latch_o  (latch_q),
    .reload_o (reload_stb),
    .en_o     (en_q),
    .mode_o   (mode_q),
    .irq_o    (irq),
    .wr_hit_o (any_wr)
  );

  assign watch = decode_mode(mode_q);

  cyc_irq_count #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick     (cyc_en),
    .en       (en_q),
    .watch    (watch),
    .hold     (any_wr),
    .reload   (reload_stb),
    .load_val (latch_q),
    .cnt_o    (cnt_q),
    .fire_o   (fire)
  );
endmodule

// File: rtl/cyc_irq_timer_chk.sv
module cyc_irq_timer_chk #(
  parameter int unsigned       ADDR_W      = 16,
  parameter int unsigned       CNT_W       = 16,
  parameter logic [ADDR_W-1:0] RELOAD_ADDR = 16'hF000,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 16'hF001
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_we,
  input logic              cyc_en,
  input logic              irq,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  latch,
  input logic              en,
  input logic              any_wr
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic reload_wr;
  logic ctrl_wr;
  assign reload_wr = cpu_we && (cpu_addr == RELOAD_ADDR);
  assign ctrl_wr   = cpu_we && (cpu_addr == CTRL_ADDR);

  AST_RELOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    reload_wr |=> count == $past(latch)); // R2
  AST_CTRL_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !irq); // R3
  AST_HOLD_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (any_wr && !reload_wr) |=> $stable(count)); // R4
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !any_wr) |=> $stable(count)); // R4
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cyc_en && count != '0 && !any_wr) |=> (count == $past(count) - ONE || count == '0)); // R4
  AST_FIRE_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (count == '0 && !en)); // R9
  AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !any_wr) |=> count == '0); // R9
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ctrl_wr) |=> irq); // R10
endmodule

bind cyc_irq_timer cyc_irq_timer_chk #(
  .ADDR_W      (ADDR_W),
  .CNT_W       (CNT_W),
  .RELOAD_ADDR (RELOAD_ADDR),
  .CTRL_ADDR   (CTRL_ADDR)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .cpu_addr (cpu_addr),
  .cpu_we   (cpu_we),
  .cyc_en   (cyc_en),
  .irq      (irq),
  .count    (cnt_q),
  .latch    (latch_q),
  .en       (en_q),
  .any_wr   (any_wr)
);

// File: tb/cyc_irq_timer_bench.sv
module cyc_irq_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [3:0]  cpu_data;
  logic        cpu_we;
  logic        cyc_en;
  logic        irq;

  int checks   = 0;
  int failures = 0;
  int pulse_cnt = 0;
  bit finished = 1'b0;

  typedef struct {
    int    pulses;
    string req;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  cyc_irq_timer u_cyc_irq_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_addr (cpu_addr),
    .cpu_data (cpu_data),
    .cpu_we   (cpu_we),
    .cyc_en   (cyc_en),
    .irq      (irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: each rise of irq must match the head of the scoreboard
  initial begin
    forever begin
      @(posedge irq);
      if (exp_q.size() == 0) begin
        checks++;
        failures++;
        $display("FAIL unexpected irq actual=%0d expected=0 (no firing due)", pulse_cnt);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(pulse_cnt == e.pulses, e.req, pulse_cnt, e.pulses);
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [3:0] d, input bit with_pulse);
    @(negedge clk);
    cpu_addr = a;
    cpu_data = d;
    cpu_we   = 1'b1;
    cyc_en   = with_pulse;
    @(negedge clk);
    cpu_we   = 1'b0;
    cyc_en   = 1'b0;
  endtask

  task automatic set_latch(input logic [15:0] v);
    wr(16'hE003, v[15:12], 1'b0);
    wr(16'hE002, v[11:8], 1'b0);
    wr(16'hE001, v[7:4], 1'b0);
    wr(16'hE000, v[3:0], 1'b0);
  endtask

  task automatic pulses(input int max);
    for (int i = 0; i < max; i++) begin
      @(negedge clk);
      if (irq) begin
        cyc_en = 1'b0;
        break;
      end
      cyc_en = 1'b1;
      pulse_cnt++;
    end
    @(negedge clk);
    cyc_en = 1'b0;
  endtask

  // expect a firing on pulse number n; the scoreboard entry is popped by the monitor
  task automatic expect_fire(input int n, input string req);
    exp_t e;
    pulse_cnt = 0;
    e.pulses = n;
    e.req    = req;
    exp_q.push_back(e);
    pulses(n + 8);
    chk(exp_q.size() == 0, {req, " firing missing"}, exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic expect_quiet(input int n, input string req);
    pulse_cnt = 0;
    pulses(n);
    chk(irq == 1'b0, req, irq, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    cpu_addr = '0;
    cpu_data = '0;
    cpu_we = 1'b0;
    cyc_en = 1'b0;
    do_reset();

    // R11: irq low after reset
    chk(irq == 1'b0, "R11 reset irq", irq, 0);

    // R11 R8: counter resets to 0xFFFF; mode 4 fires at (0xF)+1
    wr(16'hF001, 4'h9, 1'b0);
    expect_fire(16, "R11 R8 reset counter mode4");

    // R10: request holds high; R3: control write clears it
    repeat (5) @(negedge clk);
    chk(irq == 1'b1, "R10 irq sticky", irq, 1);
    wr(16'hF001, 4'h0, 1'b0);
    chk(irq == 1'b0, "R3 control write clears irq", irq, 0);

    // R1 R2 R6: nibble-built value 0x2345, mode 1 -> 0x345+1
    set_latch(16'h2345);
    wr(16'hF000, 4'h0, 1'b0);
    wr(16'hF001, 4'h3, 1'b0);
    expect_fire(838, "R1 R2 R6 mode1 0x2345");

    // R1 R7: only nibble 0 rewritten -> 0x2340, mode 2 and mode 3 -> 0x40+1
    wr(16'hE000, 4'h0, 1'b0);
    wr(16'hF000, 4'h0, 1'b0);
    wr(16'hF001, 4'h5, 1'b0);
    expect_fire(65, "R1 R7 mode2 0x2340");
    wr(16'hF000, 4'h0, 1'b0);
    wr(16'hF001, 4'h7, 1'b0);
    expect_fire(65, "R7 mode3 0x2340");

    // R9: firing left counter at zero; re-enabling in mode 0 without reload stays silent
    wr(16'hF001, 4'h1, 1'b0);
    expect_quiet(300, "R9 counter zero after firing");

    // R5: mode 0 with 0x0123 fires on pulse 291
    set_latch(16'h0123);
    wr(16'hF000, 4'h0, 1'b0);
    wr(16'hF001, 4'h1, 1'b0);
    expect_fire(291, "R5 mode0 0x0123");

    // R5: mode 0 boundary, value 1 fires on the first pulse
    set_latch(16'h0001);
    wr(16'hF000, 4'h0, 1'b0);
    wr(16'hF001, 4'h1, 1'b0);
    expect_fire(1, "R5 mode0 value1");

    // R8: mode 7, low nibble zero -> first pulse fires
    set_latch(16'h00A0);
    wr(16'hF000, 4'h0, 1'b0);
    wr(16'hF001, 4'hF, 1'b0);
    expect_fire(1, "R8 mode7 0x00A0");

    // R8: mode 5 with 0xFFFF -> 16
    set_latch(16'hFFFF);
    wr(16'hF000, 4'h0, 1'b0);
    wr(16'hF001, 4'hB, 1'b0);
    expect_fire(16, "R8 mode5 0xFFFF");

    // R12: mode 1 with 0x0005 counts to zero without crossing, no firing
    set_latch(16'h0005);
    wr(16'hF000, 4'h0, 1'b0);
    wr(16'hF001, 4'h3, 1'b0);
    expect_quiet(40, "R12 mode1 silent stop");
    wr(16'hF001, 4'h1, 1'b0);
    expect_quiet(20, "R12 counter stayed at zero");

    // R4: enable clear stops counting
    set_latch(16'h0004);
    wr(16'hF000, 4'h0, 1'b0);
    wr(16'hF001, 4'h0, 1'b0);
    expect_quiet(10, "R4 disabled no count");
    wr(16'hF001, 4'h1, 1'b0);
    expect_fire(4, "R4 count resumes from loaded value");

    // R4: writes in the same cycle as a pulse suppress that decrement
    set_latch(16'h0003);
    wr(16'hF000, 4'h0, 1'b0);
    wr(16'hF001, 4'h1, 1'b0);
    wr(16'hE003, 4'h0, 1'b1);
    wr(16'hE003, 4'h0, 1'b1);
    chk(irq == 1'b0, "R4 write beats pulse", irq, 0);
    expect_fire(3, "R4 write beats pulse");

    // R11: reset clears a held request
    chk(irq == 1'b1, "R10 held before reset", irq, 1);
    do_reset();
    chk(irq == 1'b0, "R11 reset clears irq", irq, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule